// File: doc/BRIEF.md
# Host Bus Slave with Wait-Line Arbitration

This block lets an external processor reach an internal register window and a display memory through a 16-bit strobe-driven bus. The same display memory is read at regular intervals by a display-refresh requester. The host side runs on its own bus clock, and the memory and arbiter run on a core clock that may be asynchronous to it. A host cycle starts when chip select and a read or write strobe are sampled low. The block then holds an active-low wait line asserted. The request crosses into the core domain, waits for the single memory port, completes, and its completion crosses back. Only then is the wait line released.

Two configuration inputs are captured while the bus reset is held. One enables the interface; when it is low, every strobe is ignored. The other selects whether the two data-bus byte lanes are swapped, which gives big-endian byte order. Byte selection follows the 8-bit convention: address bit 0 low enables the even byte, and the active-low high-byte enable selects the odd byte. A simple requester model stands in for the refresh engine. It asks for one memory word per refresh slot and reports each fetched word on its outputs.

Top module: `hbw_host_slave`

## Requirements
- R1: While either reset is held and right after it, `hb_wait_n` is 1 and `hb_doe` is 0.
- R2: With `hb_cs_n` high, a low read or write strobe is ignored: `hb_wait_n` stays 1 and memory is not written.
- R3: From the moment chip select and a strobe are both low, `hb_wait_n` is 0 until the access has completed; it is never low while `hb_cs_n` is high.
- R4: In little-endian mode, bus bits [7:0] carry the even byte of the addressed word and bits [15:8] the odd byte, for both reads and writes.
- R5: In big-endian mode, captured as `cfg_endian_big`=1 at reset, the two bus byte lanes are swapped relative to R4.
- R6: A write updates the even byte only when `hb_addr[0]`=0 and the odd byte only when `hb_bhe_n`=0; other bytes keep their value. A read always returns the full word.
- R7: `hb_doe` is 1 only for a completed read while `hb_rd_n` and `hb_cs_n` are low, and drops in the same cycle `hb_rd_n` rises.
- R8: `hb_addr[15]`=1 selects a register window of 2^REG_AW words indexed by `hb_addr[REG_AW:1]`, which resets to zero and is separate from display memory. `hb_addr[15]`=0 selects display memory indexed by `hb_addr[MEM_AW:1]`.
- R9: An address whose bits between the window index and bit 14 are not all zero is unmapped: a write there changes nothing, and a read returns 0.
- R10: A pending refresh fetch takes the memory port first. A waiting host request is granted no later than the core cycle after it loses, so each host access completes within 12 bus cycles at the bench clock ratio.
- R11: The refresh model asks for one word every REF_SLOT core cycles. Each request is granted in the cycle after it is raised. The fetched word appears on `ref_data` with `ref_valid`=1 and its index on `ref_addr` one core cycle after the grant.
- R12: When `cfg_generic_sel` is 0 at reset, no strobe is accepted: `hb_wait_n` stays 1 and memory is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Host bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain; captures configuration |
| core_clk | input | 1 | Core clock for arbiter, memory and refresh |
| core_rst | input | 1 | Synchronous active-high reset, core domain |
| cfg_generic_sel | input | 1 | Interface enable, sampled during bus reset |
| cfg_endian_big | input | 1 | Byte-lane swap select, sampled during bus reset |
| hb_addr | input | 16 | Host byte address |
| hb_din | input | 16 | Write data from host |
| hb_dout | output | 16 | Read data to host |
| hb_doe | output | 1 | Read data drive enable (high-impedance when 0) |
| hb_cs_n | input | 1 | Chip select, active low |
| hb_rd_n | input | 1 | Read strobe, active low |
| hb_we0_n | input | 1 | Write strobe, active low |
| hb_bhe_n | input | 1 | High (odd) byte enable, active low |
| hb_wait_n | output | 1 | Wait request to host, active low |
| ref_valid | output | 1 | Refresh word valid |
| ref_addr | output | MEM_AW | Word index of the refresh word |
| ref_data | output | 16 | Refresh word |

## Verification
The checks assume that address, byte enable and write data are stable while a strobe is low. They also assume a host keeps chip select and its strobe low until `hb_wait_n` returns high, and never drives both strobes at once. The stimulus changes every bus input only on the falling bus clock edge. It holds each access until the wait line releases, and it releases the strobe one cycle before starting the next access. The configuration inputs change only while both resets are held.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
    localparam int HB_AW    = 16;
    localparam int HB_DW    = 16;
    localparam int HB_BYTES = HB_DW / 8;

    typedef enum logic [1:0] {
        BS_IDLE = 2'd0,
        BS_BUSY = 2'd1,
        BS_DONE = 2'd2
    } bus_state_e;

    typedef struct packed {
        logic                wr;
        logic                is_reg;
        logic                hit;
        logic [HB_BYTES-1:0] be;
        logic [HB_DW-1:0]    wdata;
    } hcmd_t;

    // exchange the two byte lanes when big-endian order is selected
    function automatic logic [HB_DW-1:0] lane_swap(input logic [HB_DW-1:0] w,
                                                   input logic big);
        return big ? {w[7:0], w[15:8]} : w;
    endfunction
endpackage

// File: rtl/hbw_sync.sv
module hbw_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hbw_bus_side.sv
module hbw_bus_side
    import hbw_pkg::*;
#(
    parameter int MEM_AW      = 6,
    parameter int REG_AW      = 3,
    parameter int IDX_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_generic_sel,
    input  logic              cfg_endian_big,
    input  logic [HB_AW-1:0]  hb_addr,
    input  logic [HB_DW-1:0]  hb_din,
    output logic [HB_DW-1:0]  hb_dout,
    output logic              hb_doe,
    input  logic              hb_cs_n,
    input  logic              hb_rd_n,
    input  logic              hb_we0_n,
    input  logic              hb_bhe_n,
    output logic              hb_wait_n,
    output logic              req_tgl,
    output hcmd_t             cmd_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              mode_ok,
    input  logic              ack_tgl,
    input  logic [HB_DW-1:0]  rd_word
);
    bus_state_e       st_q;
    logic             big_q;
    logic             ack_s, ack_seen;
    logic             strobe, ack_edge;
    hcmd_t            cmd_d;
    logic [IDX_W-1:0] idx_d;

    hbw_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst(rst), .d(ack_tgl), .q(ack_s)
    );

    assign strobe   = mode_ok && !hb_cs_n && (!hb_rd_n || !hb_we0_n);
    assign ack_edge = ack_s ^ ack_seen;

    // address decode and lane steering for the incoming cycle
    always_comb begin
        cmd_d.wr     = !hb_we0_n;
        cmd_d.is_reg = hb_addr[HB_AW-1];
        cmd_d.hit    = cmd_d.is_reg ? (hb_addr[HB_AW-2:REG_AW+1] == '0)
                                    : (hb_addr[HB_AW-2:MEM_AW+1] == '0);
        cmd_d.be     = {!hb_bhe_n, !hb_addr[0]};
        cmd_d.wdata  = lane_swap(hb_din, big_q);
        idx_d        = cmd_d.is_reg ? IDX_W'(hb_addr[REG_AW:1])
                                    : IDX_W'(hb_addr[MEM_AW:1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_ok  <= cfg_generic_sel;
            big_q    <= cfg_endian_big;
            st_q     <= BS_IDLE;
            req_tgl  <= 1'b0;
            ack_seen <= 1'b0;
            cmd_o    <= '0;
            idx_o    <= '0;
        end else begin
            ack_seen <= ack_s;
            case (st_q)
                BS_IDLE: if (strobe) begin
                    cmd_o   <= cmd_d;
                    idx_o   <= idx_d;
                    req_tgl <= ~req_tgl;
                    st_q    <= BS_BUSY;
                end
                BS_BUSY: if (ack_edge) st_q <= BS_DONE;
                BS_DONE: if (!strobe) st_q <= BS_IDLE;
                default: st_q <= BS_IDLE;
            endcase
        end
    end

    assign hb_wait_n = !(strobe && st_q != BS_DONE);
    assign hb_doe    = (st_q == BS_DONE) && !cmd_o.wr && mode_ok
                       && !hb_cs_n && !hb_rd_n;
    assign hb_dout   = lane_swap(rd_word, big_q);
endmodule

// File: rtl/hbw_arbiter.sv
module hbw_arbiter (
    input  logic ref_req,
    input  logic host_req,
    output logic ref_gnt,
    output logic host_gnt
);
    // refresh first; a refresh request lasts one cycle, so the host follows
    assign ref_gnt  = ref_req;
    assign host_gnt = host_req && !ref_req;
endmodule

// File: rtl/hbw_refresh_model.sv
module hbw_refresh_model #(
    parameter int MEM_AW   = 6,
    parameter int REF_SLOT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gnt,
    output logic              req,
    output logic [MEM_AW-1:0] fetch_idx,
    output logic              fetch_valid,
    output logic [MEM_AW-1:0] fetch_addr
);
    localparam int CNT_W = $clog2(REF_SLOT);

    logic [CNT_W-1:0] slot_cnt;
    logic             slot_end;

    assign slot_end = (slot_cnt == CNT_W'(REF_SLOT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_cnt    <= '0;
            req         <= 1'b0;
            fetch_idx   <= '0;
            fetch_valid <= 1'b0;
            fetch_addr  <= '0;
        end else begin
            slot_cnt    <= slot_end ? '0 : slot_cnt + 1'b1;
            fetch_valid <= gnt;
            if (gnt) begin
                req        <= 1'b0;
                fetch_addr <= fetch_idx;
                fetch_idx  <= fetch_idx + 1'b1;
            end
            if (slot_end) req <= 1'b1;
        end
    end
endmodule

// File: rtl/hbw_store.sv
module hbw_store
    import hbw_pkg::*;
#(
    parameter int MEM_AW = 6,
    parameter int REG_AW = 3,
    parameter int IDX_W  = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                is_reg,
    input  logic                hit,
    input  logic                we,
    input  logic [HB_BYTES-1:0] be,
    input  logic [IDX_W-1:0]    idx,
    input  logic [HB_DW-1:0]    wdata,
    output logic [HB_DW-1:0]    rdata
);
    localparam int MEM_WORDS = 1 << MEM_AW;
    localparam int REG_WORDS = 1 << REG_AW;

    logic [HB_DW-1:0] mem  [MEM_WORDS];
    logic [HB_DW-1:0] regs [REG_WORDS];
    logic [MEM_AW-1:0] m_idx;
    logic [REG_AW-1:0] r_idx;

    assign m_idx = idx[MEM_AW-1:0];
    assign r_idx = idx[REG_AW-1:0];

    always_ff @(posedge clk) begin
        if (en && we && hit && !is_reg) begin
            for (int b = 0; b < HB_BYTES; b++)
                if (be[b]) mem[m_idx][b*8 +: 8] <= wdata[b*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_WORDS; i++) regs[i] <= '0;
            rdata <= '0;
        end else if (en) begin
            if (we && hit && is_reg) begin
                for (int b = 0; b < HB_BYTES; b++)
                    if (be[b]) regs[r_idx][b*8 +: 8] <= wdata[b*8 +: 8];
            end
            if (!hit)        rdata <= '0;
            else if (is_reg) rdata <= regs[r_idx];
            else             rdata <= mem[m_idx];
        end
    end
endmodule

// File: rtl/hbw_host_slave.sv
module hbw_host_slave
    import hbw_pkg::*;
#(
    parameter int MEM_AW      = 6,
    parameter int REG_AW      = 3,
    parameter int REF_SLOT    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst,
    input  logic              core_clk,
    input  logic              core_rst,
    input  logic              cfg_generic_sel,
    input  logic              cfg_endian_big,
    input  logic [15:0]       hb_addr,
    input  logic [15:0]       hb_din,
    output logic [15:0]       hb_dout,
    output logic              hb_doe,
    input  logic              hb_cs_n,
    input  logic              hb_rd_n,
    input  logic              hb_we0_n,
    input  logic              hb_bhe_n,
    output logic              hb_wait_n,
    output logic              ref_valid,
    output logic [MEM_AW-1:0] ref_addr,
    output logic [15:0]       ref_data
);
    localparam int IDX_W = (MEM_AW > REG_AW) ? MEM_AW : REG_AW;

    logic             req_tgl, req_s, req_seen;
    logic             ack_tgl;
    logic             mode_ok;
    hcmd_t            cmd_b, hcmd;
    logic [IDX_W-1:0] idx_b, hidx;
    logic             host_pend, host_gnt, host_ph2;
    logic             ref_req, ref_gnt;
    logic [MEM_AW-1:0] ref_idx;
    logic [HB_DW-1:0] rd_word, st_rdata;

    hbw_bus_side #(
        .MEM_AW(MEM_AW), .REG_AW(REG_AW), .IDX_W(IDX_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_bus (
        .clk(bus_clk), .rst(bus_rst),
        .cfg_generic_sel(cfg_generic_sel), .cfg_endian_big(cfg_endian_big),
        .hb_addr(hb_addr), .hb_din(hb_din), .hb_dout(hb_dout), .hb_doe(hb_doe),
        .hb_cs_n(hb_cs_n), .hb_rd_n(hb_rd_n), .hb_we0_n(hb_we0_n), .hb_bhe_n(hb_bhe_n),
        .hb_wait_n(hb_wait_n), .req_tgl(req_tgl), .cmd_o(cmd_b), .idx_o(idx_b),
        .mode_ok(mode_ok), .ack_tgl(ack_tgl), .rd_word(rd_word)
    );

    hbw_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk(core_clk), .rst(core_rst), .d(req_tgl), .q(req_s)
    );

    // core-side host port: capture on request edge, complete two cycles after grant
    always_ff @(posedge core_clk) begin
        if (core_rst) begin
            req_seen  <= 1'b0;
            host_pend <= 1'b0;
            host_ph2  <= 1'b0;
            ack_tgl   <= 1'b0;
            rd_word   <= '0;
            hcmd      <= '0;
            hidx      <= '0;
        end else begin
            host_ph2 <= host_gnt;
            if (req_s != req_seen) begin
                req_seen  <= req_s;
                host_pend <= 1'b1;
                hcmd      <= cmd_b;
                hidx      <= idx_b;
            end else if (host_gnt) begin
                host_pend <= 1'b0;
            end
            if (host_ph2) begin
                ack_tgl <= ~ack_tgl;
                if (!hcmd.wr) rd_word <= st_rdata;
            end
        end
    end

    hbw_arbiter u_arb (
        .ref_req(ref_req), .host_req(host_pend),
        .ref_gnt(ref_gnt), .host_gnt(host_gnt)
    );

    hbw_refresh_model #(.MEM_AW(MEM_AW), .REF_SLOT(REF_SLOT)) u_ref (
        .clk(core_clk), .rst(core_rst), .gnt(ref_gnt), .req(ref_req),
        .fetch_idx(ref_idx), .fetch_valid(ref_valid), .fetch_addr(ref_addr)
    );

    hbw_store #(.MEM_AW(MEM_AW), .REG_AW(REG_AW), .IDX_W(IDX_W)) u_store (
        .clk(core_clk), .rst(core_rst),
        .en(ref_gnt || host_gnt),
        .is_reg(ref_gnt ? 1'b0 : hcmd.is_reg),
        .hit(ref_gnt ? 1'b1 : hcmd.hit),
        .we(ref_gnt ? 1'b0 : hcmd.wr),
        .be(hcmd.be),
        .idx(ref_gnt ? IDX_W'(ref_idx) : hidx),
        .wdata(hcmd.wdata),
        .rdata(st_rdata)
    );

    assign ref_data = st_rdata;
endmodule

// File: rtl/hbw_host_slave_chk.sv
module hbw_host_slave_chk (
    input logic bus_clk,
    input logic bus_rst,
    input logic core_clk,
    input logic core_rst,
    input logic hb_cs_n,
    input logic hb_rd_n,
    input logic hb_doe,
    input logic hb_wait_n,
    input logic mode_ok,
    input logic ref_req,
    input logic ref_gnt,
    input logic host_pend,
    input logic host_gnt
);
    p_wait_needs_cs_r3: assert property (@(posedge bus_clk) disable iff (bus_rst)
        !hb_wait_n |-> !hb_cs_n);

    p_oe_needs_rd_r7: assert property (@(posedge bus_clk) disable iff (bus_rst)
        hb_doe |-> (!hb_rd_n && !hb_cs_n));

    p_mode_off_r12: assert property (@(posedge bus_clk) disable iff (bus_rst)
        !mode_ok |-> (hb_wait_n && !hb_doe));

    p_ref_first_r10: assert property (@(posedge core_clk) disable iff (core_rst)
        ref_req |-> !host_gnt);

    p_host_no_starve_r10: assert property (@(posedge core_clk) disable iff (core_rst)
        (host_pend && !host_gnt) |=> host_gnt);

    p_ref_served_r11: assert property (@(posedge core_clk) disable iff (core_rst)
        ref_req |=> !ref_req);

    p_ref_gnt_r11: assert property (@(posedge core_clk) disable iff (core_rst)
        ref_req |-> ref_gnt);
endmodule

bind hbw_host_slave hbw_host_slave_chk u_chk (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .core_clk(core_clk), .core_rst(core_rst),
    .hb_cs_n(hb_cs_n), .hb_rd_n(hb_rd_n), .hb_doe(hb_doe), .hb_wait_n(hb_wait_n),
    .mode_ok(mode_ok), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .host_pend(host_pend), .host_gnt(host_gnt)
);

// File: tb/tb_hbw_host_slave.sv
module tb_hbw_host_slave;
    localparam int CLK_PERIOD  = 10;
    localparam int CORE_PERIOD = 7;
    localparam int MEM_AW      = 6;
    localparam int LAT_MAX     = 12;
    localparam int NVEC        = 19;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic        bhe_n;
        logic [15:0] data;
        logic [3:0]  req;
    } vec_t;

    // little-endian walk: write/read, address, high-byte enable, data or expected
    localparam vec_t VEC [NVEC] = '{
        {1'b1, 16'h0000, 1'b0, 16'h1234, 4'd6},  // R6 full word
        {1'b0, 16'h0000, 1'b0, 16'h1234, 4'd4},  // R4
        {1'b1, 16'h0001, 1'b0, 16'hAB00, 4'd6},  // R6 odd byte only
        {1'b0, 16'h0000, 1'b0, 16'hAB34, 4'd6},  // R6
        {1'b1, 16'h0000, 1'b1, 16'h00CD, 4'd6},  // R6 even byte only
        {1'b0, 16'h0000, 1'b0, 16'hABCD, 4'd4},  // R4
        {1'b1, 16'h0002, 1'b0, 16'h1111, 4'd8},  // R8
        {1'b1, 16'h8002, 1'b0, 16'h5A5A, 4'd8},  // R8
        {1'b0, 16'h0002, 1'b0, 16'h1111, 4'd8},  // R8
        {1'b0, 16'h8002, 1'b0, 16'h5A5A, 4'd8},  // R8
        {1'b0, 16'h8000, 1'b0, 16'h0000, 4'd8},  // R8 reset value
        {1'b1, 16'h0100, 1'b0, 16'h7777, 4'd9},  // R9 unmapped memory
        {1'b0, 16'h0100, 1'b0, 16'h0000, 4'd9},  // R9
        {1'b0, 16'h0000, 1'b0, 16'hABCD, 4'd9},  // R9 no alias
        {1'b1, 16'h0003, 1'b1, 16'hFFFF, 4'd6},  // R6 no byte enabled
        {1'b0, 16'h0002, 1'b0, 16'h1111, 4'd6},  // R6
        {1'b1, 16'h8080, 1'b0, 16'h3333, 4'd9},  // R9 unmapped register
        {1'b0, 16'h8000, 1'b0, 16'h0000, 4'd9},  // R9
        {1'b0, 16'h8080, 1'b0, 16'h0000, 4'd9}   // R9
    };

    logic bus_clk = 1'b0, core_clk = 1'b0;
    logic bus_rst = 1'b1, core_rst = 1'b1;
    logic cfg_generic_sel = 1'b1, cfg_endian_big = 1'b0;
    logic [15:0] hb_addr = '0, hb_din = '0;
    logic hb_cs_n = 1'b1, hb_rd_n = 1'b1, hb_we0_n = 1'b1, hb_bhe_n = 1'b1;
    logic [15:0] hb_dout, ref_data;
    logic hb_doe, hb_wait_n, ref_valid;
    logic [MEM_AW-1:0] ref_addr;

    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2)  bus_clk  = ~bus_clk;
    always #(CORE_PERIOD/2.0) core_clk = ~core_clk;

    hbw_host_slave dut (
        .bus_clk(bus_clk), .bus_rst(bus_rst), .core_clk(core_clk), .core_rst(core_rst),
        .cfg_generic_sel(cfg_generic_sel), .cfg_endian_big(cfg_endian_big),
        .hb_addr(hb_addr), .hb_din(hb_din), .hb_dout(hb_dout), .hb_doe(hb_doe),
        .hb_cs_n(hb_cs_n), .hb_rd_n(hb_rd_n), .hb_we0_n(hb_we0_n), .hb_bhe_n(hb_bhe_n),
        .hb_wait_n(hb_wait_n), .ref_valid(ref_valid), .ref_addr(ref_addr),
        .ref_data(ref_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic sel, input logic big);
        @(negedge bus_clk);
        bus_rst = 1'b1; core_rst = 1'b1;
        cfg_generic_sel = sel; cfg_endian_big = big;
        repeat (4) @(negedge bus_clk);
        chk(hb_wait_n == 1'b1 && hb_doe == 1'b0, "R1 during reset",
            {hb_wait_n, hb_doe}, 2'b10);
        bus_rst = 1'b0; core_rst = 1'b0;
        repeat (3) @(negedge bus_clk);
        chk(hb_wait_n == 1'b1 && hb_doe == 1'b0, "R1 after reset",
            {hb_wait_n, hb_doe}, 2'b10);
    endtask

    task automatic do_access(input logic wr, input logic [15:0] a, input logic bhe,
                             input logic [15:0] d, output logic [15:0] rd);
        int lat;
        @(negedge bus_clk);
        hb_addr = a; hb_bhe_n = bhe; hb_din = d; hb_cs_n = 1'b0;
        if (wr) hb_we0_n = 1'b0; else hb_rd_n = 1'b0;
        #1;
        chk(hb_wait_n == 1'b0, "R3 wait asserted", hb_wait_n, 0);
        lat = 0;
        while (hb_wait_n == 1'b0 && lat < 200) begin
            @(negedge bus_clk);
            lat++;
        end
        chk(hb_wait_n == 1'b1 && lat <= LAT_MAX, "R10 latency", lat, LAT_MAX);
        rd = hb_dout;
        if (!wr) chk(hb_doe == 1'b1, "R7 drive during read", hb_doe, 1);
        @(negedge bus_clk);
        hb_rd_n = 1'b1; hb_we0_n = 1'b1;
        #1;
        if (!wr) chk(hb_doe == 1'b0, "R7 release on rd rise", hb_doe, 0);
        hb_cs_n = 1'b1; hb_bhe_n = 1'b1;
        @(negedge bus_clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int n;
        bit seen, stuck;

        do_reset(1'b1, 1'b0);  // R1

        for (int i = 0; i < NVEC; i++) begin
            do_access(VEC[i].wr, VEC[i].addr, VEC[i].bhe_n, VEC[i].data, rd);
            if (!VEC[i].wr)
                chk(rd == VEC[i].data, $sformatf("R%0d vector %0d", VEC[i].req, i),
                    rd, VEC[i].data);
        end

        // R2: strobes with chip select high are ignored
        @(negedge bus_clk);
        hb_addr = 16'h0000; hb_din = 16'hFFFF; hb_bhe_n = 1'b0; hb_we0_n = 1'b0;
        stuck = 1'b0;
        repeat (10) begin
            @(negedge bus_clk);
            if (hb_wait_n !== 1'b1) stuck = 1'b1;
        end
        chk(!stuck, "R2 wait with cs high", stuck, 0);
        hb_we0_n = 1'b1; hb_bhe_n = 1'b1;
        do_access(1'b0, 16'h0000, 1'b0, 16'h0, rd);
        chk(rd == 16'hABCD, "R2 memory untouched", rd, 16'hABCD);

        // R11: refresh delivers word 0 contents
        seen = 1'b0;
        n = 0;
        while (!seen && n < 3000) begin
            @(negedge core_clk);
            n++;
            if (ref_valid && ref_addr == '0) seen = 1'b1;
        end
        chk(seen && ref_data == 16'hABCD, "R11 refresh word", ref_data, 16'hABCD);

        // R12: interface disabled at reset
        do_reset(1'b0, 1'b0);
        @(negedge bus_clk);
        hb_addr = 16'h0000; hb_din = 16'h0F0F; hb_bhe_n = 1'b0;
        hb_cs_n = 1'b0; hb_we0_n = 1'b0;
        stuck = 1'b0;
        repeat (20) begin
            @(negedge bus_clk);
            if (hb_wait_n !== 1'b1 || hb_doe !== 1'b0) stuck = 1'b1;
        end
        chk(!stuck, "R12 strobes ignored", stuck, 0);
        hb_we0_n = 1'b1; hb_cs_n = 1'b1; hb_bhe_n = 1'b1;

        // R5: big-endian swaps lanes; also shows the R12 write did not land
        do_reset(1'b1, 1'b1);
        do_access(1'b0, 16'h0000, 1'b0, 16'h0, rd);
        chk(rd == 16'hCDAB, "R5 big-endian read", rd, 16'hCDAB);
        do_access(1'b1, 16'h0000, 1'b0, 16'h1122, rd);
        do_reset(1'b1, 1'b0);
        do_access(1'b0, 16'h0000, 1'b0, 16'h0, rd);
        chk(rd == 16'h2211, "R5 big-endian write seen little", rd, 16'h2211);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule